// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits beside the command decoder of a double-data-rate memory controller or memory model. It holds the burst configuration word, which sets three things: the number of beats per access, the order in which columns are visited, and the read latency. A configuration command writes the word, but only when both bank-select bits are zero and every bank is idle. The block rejects a command that carries an unsupported length or latency code, and it refuses a command that arrives while a bank is open. In both cases the stored word is left as it was.

A read or write command carries a starting column. After it is accepted, the block emits one column per clock cycle for the programmed number of beats. The columns wrap inside an aligned window whose size equals the burst length. The walk is either an incrementing count or an XOR of the beat index with the start offset. The decoded latency, the ordering and the beat count are presented continuously so that neighbouring logic can use them.

Top module: `burst_col_seq`

## Requirements
- R1: After reset the block reports a burst of 2 beats, sequential order and latency 2. No beat is valid and `cmd_ready` is high.
- R2: A configuration command is loaded when all of these hold: `cfg_valid` is high, `cfg_bank` is 00, `banks_idle` is high, and both codes are legal. The word is laid out as latency in bits 6:4, order in bit 3 and length in bits 2:0. The new settings appear on the outputs the cycle after the command.
- R3: A configuration command with any nonzero `cfg_bank` is ignored. The settings do not change and no flag is raised.
- R4: A configuration command with `cfg_bank` 00 while `banks_idle` is low pulses `cfg_refused` for one cycle. The settings are unchanged.
- R5: A configuration command whose length code is not 001 to 100, or whose latency code is not 010 or 011, pulses `cfg_error` for one cycle. The settings are unchanged.
- R6: Length codes decode as 001 to 2 beats, 010 to 4, 011 to 8 and 100 to 16. Latency codes decode as 010 to 2 and 011 to 3. Order bit 0 selects sequential order and 1 selects interleaved order.
- R7: An accepted command produces exactly as many consecutive `beat_valid` cycles as the burst length. The first beat appears the cycle after acceptance, and `beat_last` is high only on the final beat.
- R8: During a burst, the column bits at and above log2(burst length) equal those of the command column.
- R9: In sequential order, the low bits of beat i are (start + i) mod the burst length.
- R10: In interleaved order, the low bits of beat i are start XOR i.
- R11: While a burst runs, `cmd_ready` is low and a presented command is ignored. The running sequence is unaffected.
- R12: Reads and writes use the same length, and `beat_write` repeats the command's write flag on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_bank | input | 2 | Bank-select bits of the configuration command |
| cfg_addr | input | 13 | Address word carrying the configuration |
| banks_idle | input | 1 | High when no bank is open |
| cfg_error | output | 1 | One-cycle pulse on a reserved code |
| cfg_refused | output | 1 | One-cycle pulse on a command while a bank is open |
| cas_lat | output | 2 | Decoded read latency (2 or 3) |
| burst_interleave | output | 1 | 1 when interleaved order is selected |
| burst_beats | output | 5 | Decoded beats per burst |
| cmd_valid | input | 1 | Read/write command strobe |
| cmd_col | input | 10 | Starting column |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_ready | output | 1 | High when a command can be accepted |
| beat_valid | output | 1 | Current beat carries a column |
| beat_last | output | 1 | Final beat of the burst |
| beat_col | output | 10 | Column for this beat |
| beat_write | output | 1 | Write flag of the running burst |

## Verification
A corrupted configuration word shows up on `burst_beats`, `cas_lat` or `burst_interleave` in the cycle after the faulty write. Because these outputs are checked after every configuration command, the fault is caught there, before any burst uses it. A wrong beat index or a wrong window mask shows up as a wrong `beat_col` on the first beat that leaves the start position. The bench compares every beat against a formula, so the fault is caught within one burst. A miscounted length shows up as `beat_last` on the wrong beat, or as `beat_valid` staying high or dropping early, which is caught at the end of that burst.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int CFG_W    = 7;
    localparam int BEATS_W  = 5;
    localparam int IDX_W    = 4;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } order_e;

    typedef struct packed {
        logic [2:0] lat;
        order_e     order;
        logic [2:0] len;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{lat: 3'b010, order: ORD_SEQ, len: 3'b001};

    function automatic logic len_legal(input logic [2:0] code);
        return (code >= 3'b001) && (code <= 3'b100);
    endfunction

    function automatic logic lat_legal(input logic [2:0] code);
        return (code == 3'b010) || (code == 3'b011);
    endfunction

    function automatic logic [BEATS_W-1:0] len_beats(input logic [2:0] code);
        logic [BEATS_W-1:0] n;
        case (code)
            3'b010:  n = BEATS_W'(4);
            3'b011:  n = BEATS_W'(8);
            3'b100:  n = BEATS_W'(16);
            default: n = BEATS_W'(2);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bcs_cfg_reg.sv
module bcs_cfg_reg
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic [BANK_W-1:0] cfg_bank,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              banks_idle,
    output cfg_t              cfg_q,
    output logic              err_o,
    output logic              refused_o
);

    cfg_t cand;
    logic hit;
    logic legal;

    assign cand  = cfg_t'(cfg_addr[CFG_W-1:0]);
    assign hit   = cfg_valid && (cfg_bank == '0);
    assign legal = len_legal(cand.len) && lat_legal(cand.lat);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= CFG_RESET;
            err_o     <= 1'b0;
            refused_o <= 1'b0;
        end else begin
            refused_o <= hit && !banks_idle;
            err_o     <= hit && banks_idle && !legal;
            if (hit && banks_idle && legal) begin
                cfg_q <= cand;
            end
        end
    end

    p_refuse_hold_r4: assert property (@(posedge clk) disable iff (rst)
        refused_o |-> $stable(cfg_q));

    p_reserved_hold_r5: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $stable(cfg_q));

    p_ignore_bank_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && cfg_bank != '0) |=> ($stable(cfg_q) && !err_o && !refused_o));

    p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({err_o, refused_o}));

    p_legal_state_r6: assert property (@(posedge clk) disable iff (rst)
        len_legal(cfg_q.len) && lat_legal(cfg_q.lat));

endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [COL_W-1:0]   cmd_col,
    input  logic               cmd_write,
    input  order_e             order_i,
    input  logic [BEATS_W-1:0] beats_i,
    output logic               ready_o,
    output logic               beat_valid,
    output logic               beat_last,
    output logic [COL_W-1:0]   beat_col,
    output logic               beat_write
);

    logic             active;
    logic [COL_W-1:0] base;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] len_m1;
    order_e           order_q;
    logic             wr_q;
    logic             accept;
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_int;
    logic [COL_W-1:0] idx_ext;

    assign accept = cmd_valid && !active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            base    <= '0;
            idx     <= '0;
            len_m1  <= '0;
            order_q <= ORD_SEQ;
            wr_q    <= 1'b0;
        end else if (accept) begin
            active  <= 1'b1;
            base    <= cmd_col;
            idx     <= '0;
            len_m1  <= IDX_W'(beats_i - BEATS_W'(1));
            order_q <= order_i;
            wr_q    <= cmd_write;
        end else if (active) begin
            if (idx == len_m1) begin
                active <= 1'b0;
            end else begin
                idx <= idx + IDX_W'(1);
            end
        end
    end

    always_comb begin
        mask     = COL_W'(len_m1);
        idx_ext  = COL_W'(idx);
        low_seq  = (base + idx_ext) & mask;
        low_int  = (base ^ idx_ext) & mask;
        beat_col = (base & ~mask) | ((order_q == ORD_INTLV) ? low_int : low_seq);
    end

    assign ready_o    = !active;
    assign beat_valid = active;
    assign beat_last  = active && (idx == len_m1);
    assign beat_write = wr_q;

    p_last_in_burst_r7: assert property (@(posedge clk) disable iff (rst)
        beat_last |-> beat_valid);

    p_no_gap_r7: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_last) |=> beat_valid);

    p_window_fixed_r8: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && $past(beat_valid) && !$past(beat_last))
            |-> (((beat_col ^ $past(beat_col)) & ~mask) == '0));

    p_busy_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_last) |=> ($stable(beat_write) && !ready_o));

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2,
    parameter int COL_W  = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_valid,
    input  logic [BANK_W-1:0]  cfg_bank,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic               banks_idle,
    output logic               cfg_error,
    output logic               cfg_refused,
    output logic [1:0]         cas_lat,
    output logic               burst_interleave,
    output logic [BEATS_W-1:0] burst_beats,
    input  logic               cmd_valid,
    input  logic [COL_W-1:0]   cmd_col,
    input  logic               cmd_write,
    output logic               cmd_ready,
    output logic               beat_valid,
    output logic               beat_last,
    output logic [COL_W-1:0]   beat_col,
    output logic               beat_write
);

    cfg_t cfg;

    bcs_cfg_reg #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) i_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_valid (cfg_valid),
        .cfg_bank  (cfg_bank),
        .cfg_addr  (cfg_addr),
        .banks_idle(banks_idle),
        .cfg_q     (cfg),
        .err_o     (cfg_error),
        .refused_o (cfg_refused)
    );

    assign cas_lat          = cfg.lat[1:0];
    assign burst_interleave = (cfg.order == ORD_INTLV);
    assign burst_beats      = len_beats(cfg.len);

    bcs_col_gen #(.COL_W(COL_W)) i_gen (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_col   (cmd_col),
        .cmd_write (cmd_write),
        .order_i   (cfg.order),
        .beats_i   (burst_beats),
        .ready_o   (cmd_ready),
        .beat_valid(beat_valid),
        .beat_last (beat_last),
        .beat_col  (beat_col),
        .beat_write(beat_write)
    );

endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_valid = 1'b0;
    logic [1:0] cfg_bank = 2'b00;
    logic [12:0] cfg_addr = '0;
    logic       banks_idle = 1'b1;
    logic       cfg_error, cfg_refused;
    logic [1:0] cas_lat;
    logic       burst_interleave;
    logic [4:0] burst_beats;
    logic       cmd_valid = 1'b0;
    logic [9:0] cmd_col = '0;
    logic       cmd_write = 1'b0;
    logic       cmd_ready, beat_valid, beat_last, beat_write;
    logic [9:0] beat_col;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    burst_col_seq i_burst_col_seq (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_bank(cfg_bank),
        .cfg_addr(cfg_addr), .banks_idle(banks_idle), .cfg_error(cfg_error),
        .cfg_refused(cfg_refused), .cas_lat(cas_lat),
        .burst_interleave(burst_interleave), .burst_beats(burst_beats),
        .cmd_valid(cmd_valid), .cmd_col(cmd_col), .cmd_write(cmd_write),
        .cmd_ready(cmd_ready), .beat_valid(beat_valid), .beat_last(beat_last),
        .beat_col(beat_col), .beat_write(beat_write)
    );

    // {cfg word[6:0], start column[9:0], write flag}
    localparam logic [17:0] VEC [8] = '{
        {7'b010_0_001, 10'h3FF, 1'b0},
        {7'b011_0_010, 10'h0A6, 1'b0},
        {7'b010_1_010, 10'h0A7, 1'b1},
        {7'b011_0_011, 10'h155, 1'b1},
        {7'b011_1_011, 10'h155, 1'b0},
        {7'b010_0_100, 10'h2AB, 1'b0},
        {7'b010_1_100, 10'h2AB, 1'b1},
        {7'b011_1_001, 10'h000, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] exp_col(input logic [9:0] s, input int i,
                                           input int len, input logic intl);
        logic [9:0] m = 10'(len - 1);
        logic [9:0] lo = intl ? ((s ^ 10'(i)) & m) : ((s + 10'(i)) & m);
        return (s & ~m) | lo;
    endfunction

    task automatic cfg_cmd(input logic [1:0] bank, input logic [6:0] word, input logic idle);
        cfg_bank   = bank;
        cfg_addr   = {6'b0, word};
        banks_idle = idle;
        cfg_valid  = 1'b1;
        @(negedge clk);
        cfg_valid  = 1'b0;
        banks_idle = 1'b1;
    endtask

    task automatic check_cfg(input string req, input int beats, input int lat, input logic intl);
        check({req, " beats"}, 32'(burst_beats), 32'(beats));
        check({req, " latency"}, 32'(cas_lat), 32'(lat));
        check({req, " order"}, 32'(burst_interleave), 32'(intl));
    endtask

    // Issue a command, then check every beat; optionally present a second
    // command mid-burst that must be ignored.
    task automatic run_burst(input string req, input logic [9:0] col, input logic wr,
                             input int len, input logic intl, input logic poke);
        cmd_col   = col;
        cmd_write = wr;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < len; i++) begin
            check({req, " R7 valid"}, 32'(beat_valid), 32'd1);
            check({req, " R7 last"}, 32'(beat_last), 32'(i == len - 1));
            check({req, " R8/R9/R10 col"}, 32'(beat_col), 32'(exp_col(col, i, len, intl)));
            check({req, " R12 write"}, 32'(beat_write), 32'(wr));
            check({req, " R11 ready"}, 32'(cmd_ready), 32'd0);
            if (poke && i == 0) begin
                cmd_col   = ~col;
                cmd_write = ~wr;
                cmd_valid = 1'b1;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        check({req, " R7 end"}, 32'(beat_valid), 32'd0);
        check({req, " R11 ready after"}, 32'(cmd_ready), 32'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_cfg("R1 reset", 2, 2, 1'b0);
        check("R1 valid", 32'(beat_valid), 32'd0);
        check("R1 ready", 32'(cmd_ready), 32'd1);

        for (int v = 0; v < 8; v++) begin
            logic [6:0] w = VEC[v][17:11];
            int len = 1 << w[2:0];
            cfg_cmd(2'b00, w, 1'b1);
            check("R2 no error", 32'(cfg_error | cfg_refused), 32'd0);
            check_cfg("R2/R6 load", len, int'(w[6:4]), w[3]);
            run_burst("vec", VEC[v][10:1], VEC[v][0], len, w[3], 1'b0);
        end

        // Known state: 8 beats, sequential, latency 3
        cfg_cmd(2'b00, 7'b011_0_011, 1'b1);
        check_cfg("R2 base", 8, 3, 1'b0);

        // R3: nonzero bank bits ignored
        cfg_cmd(2'b01, 7'b010_1_001, 1'b1);
        check("R3 flags", 32'({cfg_error, cfg_refused}), 32'd0);
        check_cfg("R3 unchanged", 8, 3, 1'b0);
        cfg_cmd(2'b10, 7'b010_1_100, 1'b1);
        check_cfg("R3 unchanged b2", 8, 3, 1'b0);

        // R4: refused while a bank is open
        cfg_cmd(2'b00, 7'b010_1_100, 1'b0);
        check("R4 refused", 32'(cfg_refused), 32'd1);
        check("R4 no error", 32'(cfg_error), 32'd0);
        check_cfg("R4 unchanged", 8, 3, 1'b0);
        @(negedge clk);
        check("R4 pulse one cycle", 32'(cfg_refused), 32'd0);

        // R5: reserved length and latency codes
        cfg_cmd(2'b00, 7'b010_0_101, 1'b1);
        check("R5 err len 101", 32'(cfg_error), 32'd1);
        check_cfg("R5 unchanged", 8, 3, 1'b0);
        cfg_cmd(2'b00, 7'b010_0_000, 1'b1);
        check("R5 err len 000", 32'(cfg_error), 32'd1);
        cfg_cmd(2'b00, 7'b001_0_010, 1'b1);
        check("R5 err lat 001", 32'(cfg_error), 32'd1);
        cfg_cmd(2'b00, 7'b100_1_010, 1'b1);
        check("R5 err lat 100", 32'(cfg_error), 32'd1);
        check_cfg("R5 unchanged 2", 8, 3, 1'b0);
        @(negedge clk);
        check("R5 pulse one cycle", 32'(cfg_error), 32'd0);

        // R11: command during a burst is ignored; sequential wrap at top of window
        run_burst("R11 busy", 10'h1FE, 1'b1, 8, 1'b0, 1'b1);

        // R12: same length for a read right after
        run_burst("R12 read", 10'h1FE, 1'b0, 8, 1'b0, 1'b0);

        // R1: reset returns defaults
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_cfg("R1 re-reset", 2, 2, 1'b0);
        run_burst("R1 default burst", 10'h201, 1'b0, 2, 1'b0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule